// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a general-purpose up-counting timer that sits on a simple word-addressed register bus. A 3-bit clock-source field selects one of several tick-enable inputs. The selected ticks pass through a 12-bit prescaler that divides them by (prescaler + 1), and each divided tick advances a counter `CNT_W` bits wide (32 by default). Three compare channels watch the counter. Each one raises its own status flag when the count arrives at its value. A rollover flag records every wrap from all-ones to zero. A single level interrupt combines the flags with their enable bits. Software can use the timer either as a free-running timebase or, in restart mode, as a periodic tick generator whose period comes from compare channel 1.

The bus has no back-pressure and accepts every strobe in the cycle it is given. It has no valid/ready handshake, because nothing streams through the block. A write lands on the clock edge where `bus_wr` is high. Read data is registered and appears one cycle after `bus_rd`. The register index is the byte address divided by four: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 to 6 compare channels 1 to 3, 7 and 8 capture registers 1 and 2, 9 counter.

The control register holds the following fields:
- bit 0: enable.
- bit 1: restart-on-enable.
- bits 3 and 5: stored hold flags.
- bits 8:6: clock source.
- bit 9: free-run.
- bit 15: software reset.
- bits 31:16: stored without further effect.

Top module: `gpt_cmp_timer`

## Requirements
- R1: After a hard reset, control, prescaler, status, interrupt enable, counter and both capture registers read 0, all three compare registers read all-ones (`CNT_W` bits, zero-extended), and `irq` is low.
- R2: Read-back widths are fixed by register:
  - The prescaler keeps bits 11:0.
  - The interrupt enable keeps bits 5:0.
  - Compare registers keep `CNT_W` bits.
  - Capture registers, the counter register and unmapped indexes ignore writes; capture registers and unmapped indexes always read 0.
- R3: Control bits 2, 4, 10 to 14 and 15 are never stored and read 0; all other control bits read back as written.
- R4: Clock-source code k, for k = 1 to `NUM_SRC`, advances the counter on `tick_in[k-1]`. Code 0 and any code above `NUM_SRC` never advance the counter.
- R5: With prescaler value p, the counter advances once per p+1 selected ticks. A prescaler write restarts the division phase.
- R6: The status register is write-one-to-clear. Bits 0 to 2 are compare channels 1 to 3, bits 3 and 4 are capture flags that are never set, and bit 5 is rollover. Writing 0 to a bit leaves it unchanged.
- R7: `irq` is high exactly when some status bit and the enable bit in the same position are both 1 and control bit 0 is 1.
- R8: In restart mode (control bit 9 = 0), the first advancing tick after the count equals compare 1 reloads the count to 0. Any write to compare 1 in this mode clears the count; in free-run mode such a write leaves the count alone.
- R9: In free-run mode, the counter wraps from all-ones to 0. Every wrap from all-ones to 0 sets status bit 5.
- R10: A compare flag is set on the tick that brings the count to that channel's value. Channels sharing a value set their flags on the same tick.
- R11: Writing control with bit 15 set resets the timer as a hard reset would, except control bits 0, 1, 3, 5 and 8:6, which take the written value; a still-enabled timer keeps counting from 0.
- R12: A control write that takes bit 0 from 0 to 1 with bit 1 set clears the count; with bit 1 clear the count resumes from its held value, and while bit 0 is 0 the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_in | input | NUM_SRC | Tick-enable inputs selectable as count source |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, counter steps and flag updates all take effect at the clock edge where their strobe or tick is sampled. As a result, `irq` and the register state are correct one edge later. A read returns its value one further edge after `bus_rd`. The bench drives every strobe and tick on a falling edge and samples `irq` and `bus_rdata` on the next falling edge, so every result is observed exactly one rising edge after its cause. Ticks are held low while registers are read, so a read never races a count step.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int BUS_W   = 32;
  localparam int NFLAG   = 6;
  localparam int NUM_CMP = 3;
  localparam int SRC_W   = 3;

  // register indexes (byte address / 4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_PRE  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_IEN  = 3;
  localparam int IDX_CMP1 = 4;
  localparam int IDX_CMP2 = 5;
  localparam int IDX_CMP3 = 6;
  localparam int IDX_CAP1 = 7;
  localparam int IDX_CAP2 = 8;
  localparam int IDX_CNT  = 9;

  // control bit positions
  localparam int C_EN     = 0;
  localparam int C_ENMOD  = 1;
  localparam int C_SRC_LO = 6;
  localparam int C_FREE   = 9;
  localparam int C_SWR    = 15;

  // bits never stored, and bits surviving a software reset
  localparam logic [BUS_W-1:0] CTRL_VOID = 32'h0000_FC14;
  localparam logic [BUS_W-1:0] CTRL_KEEP = 32'h0000_01EB;

  // status / enable bit positions
  localparam int F_CMP1 = 0;
  localparam int F_ROLL = 5;
endpackage

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen #(
  parameter int NUM_SRC = 4,
  parameter int PRE_W   = 12,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               div_clr,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] tick_in,
  input  logic [PRE_W-1:0]   pre_div,
  output logic               step
);
  logic [NUM_SRC-1:0] src_hit;
  logic               src_tick;
  logic [PRE_W-1:0]   div_q;
  logic               div_last;

  // code k selects line k-1; code 0 and codes past NUM_SRC select nothing
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = tick_in[g] && (src_sel == SRC_W'(g + 1));
  end

  assign src_tick = |src_hit;
  assign div_last = (div_q == pre_div);
  assign step     = run && src_tick && div_last;

  always_ff @(posedge clk) begin
    if (!rst_n || div_clr) begin
      div_q <= '0;
    end else if (run && src_tick) begin
      div_q <= div_last ? '0 : div_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            step,
  input  logic                            free_run,
  input  logic                            clear,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
  output logic [CNT_W-1:0]                cnt_q,
  output logic [NUM_CMP-1:0]              cmp_hit,
  output logic                            roll_hit
);
  logic             at_max;
  logic             reload;
  logic [CNT_W-1:0] cnt_nxt;
  logic             adv;

  assign at_max  = &cnt_q;
  assign reload  = !free_run && (cnt_q == cmp_val[0]);
  assign cnt_nxt = (reload || at_max) ? '0 : cnt_q + CNT_W'(1);
  assign adv     = step && !clear;

  // flags come from the value the counter is about to take
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign cmp_hit[g] = adv && (cnt_nxt == cmp_val[g]);
  end
  assign roll_hit = adv && at_max;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/gpt_flags.sv
module gpt_flags #(
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [NFLAG-1:0] w1c_mask,
  input  logic [NFLAG-1:0] set_in,
  input  logic [NFLAG-1:0] ien,
  input  logic             run,
  output logic [NFLAG-1:0] flags_q,
  output logic             irq
);
  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~w1c_mask) | set_in;
    end
  end

  assign irq = run && |(flags_q & ien);
endmodule

// File: rtl/gpt_cmp_timer.sv
module gpt_cmp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 12,
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0] tick_in,
  output logic               irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]                  word;
  logic                              wr_ctrl, wr_pre, wr_stat, wr_ien;
  logic [NUM_CMP-1:0]                wr_cmp;
  logic                              sw_rst, en_rise, cnt_clr, div_clr;
  logic [BUS_W-1:0]                  ctrl_q;
  logic [PRE_W-1:0]                  pre_q;
  logic [NFLAG-1:0]                  ien_q;
  logic [NUM_CMP-1:0][CNT_W-1:0]     cmp_q;
  logic [CNT_W-1:0]                  cnt_q;
  logic [NFLAG-1:0]                  flags_q;
  logic [NFLAG-1:0]                  evt;
  logic [NUM_CMP-1:0]                cmp_hit;
  logic                              roll_hit;
  logic                              step;
  logic                              run, free_run;

  assign word     = bus_addr[ADDR_W-1:2];
  assign run      = ctrl_q[C_EN];
  assign free_run = ctrl_q[C_FREE];

  assign wr_ctrl = bus_wr && (int'(word) == IDX_CTRL);
  assign wr_pre  = bus_wr && (int'(word) == IDX_PRE);
  assign wr_stat = bus_wr && (int'(word) == IDX_STAT);
  assign wr_ien  = bus_wr && (int'(word) == IDX_IEN);
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_wcmp
    assign wr_cmp[g] = bus_wr && (int'(word) == IDX_CMP1 + g);
  end

  assign sw_rst  = wr_ctrl && bus_wdata[C_SWR];
  assign en_rise = wr_ctrl && !sw_rst && !ctrl_q[C_EN] &&
                   bus_wdata[C_EN] && bus_wdata[C_ENMOD];
  assign cnt_clr = sw_rst || en_rise || (wr_cmp[0] && !free_run);
  assign div_clr = sw_rst || wr_pre;

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata & ~CTRL_VOID & (sw_rst ? CTRL_KEEP : '1);
    end
  end

  // prescaler and interrupt enable
  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      pre_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_pre) pre_q <= bus_wdata[PRE_W-1:0];
      if (wr_ien) ien_q <= bus_wdata[NFLAG-1:0];
    end
  end

  // compare channels
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n || sw_rst) begin
        cmp_q[g] <= '1;
      end else if (wr_cmp[g]) begin
        cmp_q[g] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  gpt_tick_gen #(
    .NUM_SRC (NUM_SRC),
    .PRE_W   (PRE_W),
    .SRC_W   (SRC_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_clr (div_clr),
    .src_sel (ctrl_q[C_SRC_LO +: SRC_W]),
    .tick_in (tick_in),
    .pre_div (pre_q),
    .step    (step)
  );

  gpt_counter #(
    .CNT_W   (CNT_W),
    .NUM_CMP (NUM_CMP)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .free_run (free_run),
    .clear    (cnt_clr),
    .cmp_val  (cmp_q),
    .cnt_q    (cnt_q),
    .cmp_hit  (cmp_hit),
    .roll_hit (roll_hit)
  );

  always_comb begin
    evt = '0;
    evt[F_CMP1 +: NUM_CMP] = cmp_hit;
    evt[F_ROLL]            = roll_hit;
  end

  gpt_flags #(
    .NFLAG (NFLAG)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (sw_rst),
    .w1c_mask (wr_stat ? bus_wdata[NFLAG-1:0] : '0),
    .set_in   (evt),
    .ien      (ien_q),
    .run      (run),
    .flags_q  (flags_q),
    .irq      (irq)
  );

  // registered read mux; capture and unmapped indexes return zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (int'(word))
        IDX_CTRL: bus_rdata <= ctrl_q;
        IDX_PRE:  bus_rdata <= BUS_W'(pre_q);
        IDX_STAT: bus_rdata <= BUS_W'(flags_q);
        IDX_IEN:  bus_rdata <= BUS_W'(ien_q);
        IDX_CMP1: bus_rdata <= BUS_W'(cmp_q[0]);
        IDX_CMP2: bus_rdata <= BUS_W'(cmp_q[1]);
        IDX_CMP3: bus_rdata <= BUS_W'(cmp_q[2]);
        IDX_CNT:  bus_rdata <= BUS_W'(cnt_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpt_check.sv
module gpt_check #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [IDX_W-1:0] word,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic             run,
  input logic             free_run,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp1,
  input logic [5:0]       flags,
  input logic [5:0]       ien
);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> run);

  assert_count_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_hold_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> $stable(cnt));

  assert_restart_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !free_run && cnt == cmp1 && !bus_wr) |=> cnt == '0);

  assert_rollover_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && free_run && (&cnt) && !bus_wr) |=> flags[5]);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == IDX_W'(0) && bus_wdata[15]) |=>
      (cnt == '0 && ien == '0 && flags == '0));

  assert_capture_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (word == IDX_W'(7) || word == IDX_W'(8))) |=> bus_rdata == '0);
endmodule

bind gpt_cmp_timer gpt_check #(
  .CNT_W (CNT_W),
  .IDX_W (IDX_W)
) u_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .word      (word),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .run       (run),
  .free_run  (free_run),
  .step      (step),
  .cnt       (cnt_q),
  .cmp1      (cmp_q[0]),
  .flags     (flags_q),
  .ien       (ien_q)
);

// File: tb/sim_gpt_cmp_timer.sv
module sim_gpt_cmp_timer;
  localparam int CLK_NS = 10;
  localparam int CW     = 8;
  localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, FREE = 32'h200, SWR = 32'h8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_in = '0;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpt_cmp_timer #(.CNT_W(CW), .PRE_W(12), .NUM_SRC(4), .ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .irq(irq));

  function automatic logic [31:0] src(int k);
    return 32'(k) << 6;
  endfunction

  task automatic done();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(idx * 4); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, int idx, logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 6'(idx * 4);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic tick(int ln, int n);
    repeat (n) begin
      @(negedge clk);
      tick_in = 4'(1 << ln);
    end
    @(negedge clk);
    tick_in = '0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_run++; n_fail++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    done();
  end

  initial begin
    int ms[4] = '{3, 5, 9, 30};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 hard reset values
    rd_chk("R1 ctrl", 0, 0);  rd_chk("R1 pre", 1, 0);  rd_chk("R1 stat", 2, 0);
    rd_chk("R1 ien", 3, 0);   rd_chk("R1 cmp1", 4, 32'hFF);
    rd_chk("R1 cmp2", 5, 32'hFF); rd_chk("R1 cmp3", 6, 32'hFF);
    rd_chk("R1 cap1", 7, 0);  rd_chk("R1 cap2", 8, 0);  rd_chk("R1 cnt", 9, 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 control read-back mask
    wr(0, 32'hFFFF_7FFF);
    rd_chk("R3 ctrl mask", 0, 32'hFFFF_03EB);
    wr(0, 0);

    // R2 widths and ignored writes
    wr(1, 32'hFFFF);  rd_chk("R2 pre width", 1, 32'hFFF);
    wr(3, 32'hFF);    rd_chk("R2 ien width", 3, 32'h3F);
    wr(5, 32'h1234);  rd_chk("R2 cmp width", 5, 32'h34);
    wr(7, 32'h5);     rd_chk("R2 cap ignores write", 7, 0);
    wr(12, 32'hA5);   rd_chk("R2 unmapped", 12, 0);
    wr(9, 32'h55);    rd_chk("R2 cnt read-only", 9, 0);
    wr(1, 0); wr(3, 0); wr(5, 32'hFF);

    // R4 clock-source sweep
    for (int code = 0; code < 8; code++) begin
      wr(0, EN | src(code));
      for (int ln = 0; ln < 4; ln++) begin
        wr(4, 32'hFF);
        tick(ln, 3);
        rd_chk($sformatf("R4 code %0d line %0d", code, ln), 9,
               (code >= 1 && code <= 4 && ln == code - 1) ? 3 : 0);
      end
    end

    // R5 prescaler sweep
    wr(0, EN | src(1));
    for (int p = 0; p < 4; p++) begin
      for (int t = 5; t <= 12; t += 7) begin
        wr(1, 32'(p));
        wr(4, 32'hFF);
        tick(0, t);
        rd_chk($sformatf("R5 pre %0d ticks %0d", p, t), 9, 32'(t / (p + 1)));
      end
    end
    wr(1, 0);

    // R8 restart mode period sweep
    foreach (ms[i]) begin
      wr(4, 32'(ms[i]));
      wr(2, 32'h3F);
      tick(0, 20);
      rd_chk($sformatf("R8 period cmp %0d", ms[i]), 9, 32'(20 % (ms[i] + 1)));
      rd_chk($sformatf("R10 flag cmp %0d", ms[i]), 2, (20 >= ms[i]) ? 1 : 0);
    end
    wr(4, 9);
    rd_chk("R8 cmp1 write clears", 9, 0);

    // R12 enable rise with restart-on-enable, R9 free-run wrap
    tick(0, 4);
    wr(0, FREE | src(1));
    wr(0, EN | ENMOD | FREE | src(1));
    rd_chk("R12 enmod restart", 9, 0);
    wr(2, 32'h3F);
    tick(0, 255);
    rd_chk("R9 count to max", 9, 32'hFF);
    rd_chk("R10 flags at max", 2, 32'h07);
    tick(0, 1);
    rd_chk("R9 wrap", 9, 0);
    rd_chk("R9 rollover flag", 2, 32'h27);
    tick(0, 5);
    wr(4, 32'h40);
    rd_chk("R8 free-run cmp1 write keeps count", 9, 5);

    // R10 simultaneous and separate compare flags
    wr(4, 12); wr(5, 12); wr(6, 12);
    wr(2, 32'h3F);
    tick(0, 6);
    rd_chk("R10 before match", 2, 0);
    tick(0, 1);
    rd_chk("R10 joint match", 2, 32'h07);
    wr(5, 16); wr(6, 20);
    wr(2, 32'h3F);
    tick(0, 4);
    rd_chk("R10 cmp2 only", 2, 32'h02);
    tick(0, 4);
    rd_chk("R10 cmp3 added", 2, 32'h06);

    // R6 write-one-to-clear
    wr(2, 32'h04);  rd_chk("R6 clear one bit", 2, 32'h02);
    wr(2, 32'h00);  rd_chk("R6 zero write no effect", 2, 32'h02);
    wr(2, 32'h3F);  rd_chk("R6 clear all", 2, 0);

    // R7 interrupt
    wr(5, 21);
    tick(0, 1);
    rd_chk("R10 cmp2 event", 2, 32'h02);
    chk("R7 irq masked", 32'(irq), 0);
    wr(3, 32'h02);  chk("R7 irq enabled", 32'(irq), 1);
    wr(3, 32'h01);  chk("R7 other enable", 32'(irq), 0);
    wr(3, 32'h02);
    wr(0, FREE | src(1));
    chk("R7 irq off when disabled", 32'(irq), 0);

    // R12 hold while disabled, resume without restart-on-enable
    tick(0, 3);
    rd_chk("R12 hold while off", 9, 21);
    wr(0, EN | FREE | src(1));
    chk("R7 irq back on", 32'(irq), 1);
    rd_chk("R12 resume value", 9, 21);
    tick(0, 2);
    rd_chk("R12 resume counting", 9, 23);

    // R11 software reset
    wr(1, 3); wr(3, 32'h3F); wr(4, 7);
    wr(0, EN | ENMOD | 32'h8 | 32'h20 | src(2) | FREE | 32'h0010_0000 | SWR);
    rd_chk("R11 ctrl kept bits", 0, 32'h0000_00AB);
    rd_chk("R11 pre", 1, 0);   rd_chk("R11 stat", 2, 0);  rd_chk("R11 ien", 3, 0);
    rd_chk("R11 cmp1", 4, 32'hFF); rd_chk("R11 cmp2", 5, 32'hFF);
    rd_chk("R11 cmp3", 6, 32'hFF); rd_chk("R11 cnt", 9, 0);
    chk("R11 irq", 32'(irq), 0);
    tick(1, 4);
    rd_chk("R11 keeps running", 9, 4);

    done();
  end
endmodule